// File: doc/BRIEF.md
# Wiper Register Command Executor

This block keeps the position registers of three digitally set wipers: two 9-bit channels with 512 positions and one 7-bit channel with 128 positions. Each wiper register has a matching shadow register that stands in for a nonvolatile location. The wiper value can be loaded directly. A 4-bit command set also acts on it: restore from the shadow, save to the shadow, step up or down by one, and halve or double for ±6 dB moves. A command acts either on one addressed channel or on all three at once.

An upstream serial front end drives the command and write strobes and watches `busy_o`. While a save or restore window is open, the block drops new requests and reports each dropped request on `reject_o`. A recall input reloads every wiper from its shadow at any time. A protect input freezes all contents but still lets the registers be reloaded from their shadows. Each wiper position leaves the block in its own zero-extended 9-bit slot of `wiper_flat_o`, with channel 0 in the lowest slot.

Top module: `wiper_cmd_engine`

## Requirements
- R1: After `rst_n` is asserted, every wiper and every shadow holds midscale (256, 256, 64), and `busy_o` and `reject_o` are low.
- R2: An accepted direct write loads `wr_data_i` into channel `wr_chan_i`, truncated to that channel's low bits (9 bits for channels 0 and 1, 7 bits for channel 2), visible one cycle later, with no busy window.
- R3: Commands 4'hA/4'hB step the addressed channel or all channels up by one and saturate at full scale (511 or 127). Commands 4'h5/4'h6 step down by one and saturate at 0.
- R4: Commands 4'h8/4'h9 double the value. A value of 0 becomes 1, and a value at or above midscale (256 or 64) becomes full scale.
- R5: Commands 4'h3/4'h4 halve the value by a right shift that drops the LSB.
- R6: Command 4'h2 copies the addressed wiper into its shadow and holds `busy_o` high for exactly STORE_CYC cycles.
- R7: Command 4'h1 (addressed channel), command 4'h7 (all channels) and a high `recall_i` load the wipers from their shadows and hold `busy_o` high for at least RESTORE_CYC cycles.
- R8: A command or write that arrives while `busy_o` is high, or in the same cycle as `recall_i`, changes nothing and sets `reject_o` high in the next cycle. If a write and a command arrive together, the command runs and the write is dropped and flagged.
- R9: While `wr_protect_i` is high, direct writes and commands 4'h2, 4'h3–4'h6 and 4'h8–4'hB change nothing and are flagged on `reject_o`. Restores and recall still act.
- R10: Command 4'h0, codes 4'hC–4'hF, and addressed commands with channel index 3 change nothing, raise no busy window and are not flagged.
- R11: An all-channel command updates all three wipers on the same clock edge, each clamped to its own width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recall_i | input | 1 | Reload all wipers from their shadows |
| wr_protect_i | input | 1 | Freeze contents, except restores |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 4 | Command code |
| cmd_chan_i | input | 2 | Channel addressed by a single-channel command |
| wr_valid_i | input | 1 | Direct-write strobe |
| wr_chan_i | input | 2 | Channel for the direct write |
| wr_data_i | input | 9 | Direct-write value |
| busy_o | output | 1 | Save or restore window open |
| reject_o | output | 1 | The previous cycle's request was dropped |
| wiper_flat_o | output | 27 | Three 9-bit wiper slots, channel 0 lowest |

## Verification
The assertions assume that the strobes, codes and channel fields are synchronous to `clk` and hold known values whenever a strobe is high. They also assume that `recall_i` is a one-cycle request like the others. The bench changes every input on the falling edge and drops each strobe after one cycle. It waits for `busy_o` to fall before it sends a request, except in the cases that deliberately probe rejection during a busy window or against a simultaneous recall.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  typedef enum logic [3:0] {
    CMD_NOP         = 4'h0,
    CMD_RESTORE_ONE = 4'h1,
    CMD_STORE_ONE   = 4'h2,
    CMD_SHR_ONE     = 4'h3,
    CMD_SHR_ALL     = 4'h4,
    CMD_DEC_ONE     = 4'h5,
    CMD_DEC_ALL     = 4'h6,
    CMD_RESTORE_ALL = 4'h7,
    CMD_SHL_ONE     = 4'h8,
    CMD_SHL_ALL     = 4'h9,
    CMD_INC_ONE     = 4'hA,
    CMD_INC_ALL     = 4'hB
  } wcmd_e;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_LOAD,
    OP_RESTORE,
    OP_INC,
    OP_DEC,
    OP_SHL,
    OP_SHR
  } chop_e;

endpackage

// File: rtl/wiper_step_unit.sv
module wiper_step_unit
  import wiper_pkg::*;
#(
  parameter int W = 9
) (
  input  chop_e          op_i,
  input  logic [W-1:0]   cur_i,
  input  logic [W-1:0]   load_i,
  input  logic [W-1:0]   shadow_i,
  output logic [W-1:0]   nxt_o
);

  localparam logic [W-1:0] FULL = '1;
  localparam logic [W-1:0] MID  = W'(1) << (W - 1);

  always_comb begin
    nxt_o = cur_i;
    case (op_i)
      OP_LOAD:    nxt_o = load_i;
      OP_RESTORE: nxt_o = shadow_i;
      OP_INC:     nxt_o = (cur_i == FULL) ? FULL : cur_i + W'(1);
      OP_DEC:     nxt_o = (cur_i == '0) ? '0 : cur_i - W'(1);
      OP_SHL: begin
        if (cur_i == '0)        nxt_o = W'(1);
        else if (cur_i >= MID)  nxt_o = FULL;
        else                    nxt_o = cur_i << 1;
      end
      OP_SHR:     nxt_o = cur_i >> 1;
      default:    nxt_o = cur_i;
    endcase
  end

endmodule

// File: rtl/wiper_channel.sv
module wiper_channel
  import wiper_pkg::*;
#(
  parameter int W    = 9,
  parameter int WMAX = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  chop_e           op_i,
  input  logic            store_i,
  input  logic [WMAX-1:0] data_i,
  output logic [WMAX-1:0] wiper_o
);

  localparam logic [W-1:0] MID = W'(1) << (W - 1);

  logic [W-1:0] wiper_q, wiper_d;
  logic [W-1:0] shadow_q;
  logic         wiper_en;

  wiper_step_unit #(.W(W)) step_i (
    .op_i     (op_i),
    .cur_i    (wiper_q),
    .load_i   (data_i[W-1:0]),
    .shadow_i (shadow_q),
    .nxt_o    (wiper_d)
  );

  assign wiper_en = (op_i != OP_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wiper_q <= MID;
    else if (wiper_en) wiper_q <= wiper_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       shadow_q <= MID;
    else if (store_i) shadow_q <= wiper_q;
  end

  assign wiper_o = WMAX'(wiper_q);

endmodule

// File: rtl/wiper_busy_timer.sv
module wiper_busy_timer #(
  parameter int STORE_CYC   = 40,
  parameter int RESTORE_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic store_start_i,
  input  logic restore_start_i,
  output logic busy_o
);

  localparam int MAXC = (STORE_CYC > RESTORE_CYC) ? STORE_CYC : RESTORE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (store_start_i)
      cnt_d = CW'(STORE_CYC);
    else if (restore_start_i && (cnt_q < CW'(RESTORE_CYC)))
      cnt_d = CW'(RESTORE_CYC);
    else if (cnt_q != '0)
      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/wiper_cmd_engine.sv
module wiper_cmd_engine
  import wiper_pkg::*;
#(
  parameter  int N_WIDE      = 2,
  parameter  int N_NARROW    = 1,
  parameter  int W_WIDE      = 9,
  parameter  int W_NARROW    = 7,
  parameter  int STORE_CYC   = 40,
  parameter  int RESTORE_CYC = 6,
  localparam int NCH         = N_WIDE + N_NARROW,
  localparam int WMAX        = (W_WIDE > W_NARROW) ? W_WIDE : W_NARROW,
  localparam int SELW        = (NCH > 1) ? $clog2(NCH + 1) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                recall_i,
  input  logic                wr_protect_i,
  input  logic                cmd_valid_i,
  input  logic [3:0]          cmd_code_i,
  input  logic [SELW-1:0]     cmd_chan_i,
  input  logic                wr_valid_i,
  input  logic [SELW-1:0]     wr_chan_i,
  input  logic [WMAX-1:0]     wr_data_i,
  output logic                busy_o,
  output logic                reject_o,
  output logic [NCH*WMAX-1:0] wiper_flat_o
);

  chop_e cmd_op;
  logic  cmd_all, cmd_mut, cmd_store;
  chop_e ch_op [NCH];
  logic  [NCH-1:0] ch_store;
  logic  chan_ok;
  logic  store_start, restore_start;
  logic  reject_d, reject_q;

  // Command decode: operation kind, scope and whether protection applies.
  always_comb begin
    cmd_op    = OP_HOLD;
    cmd_all   = 1'b0;
    cmd_mut   = 1'b0;
    cmd_store = 1'b0;
    case (cmd_code_i)
      CMD_RESTORE_ONE: cmd_op = OP_RESTORE;
      CMD_RESTORE_ALL: begin cmd_op = OP_RESTORE; cmd_all = 1'b1; end
      CMD_STORE_ONE:   begin cmd_store = 1'b1; cmd_mut = 1'b1; end
      CMD_SHR_ONE:     begin cmd_op = OP_SHR; cmd_mut = 1'b1; end
      CMD_SHR_ALL:     begin cmd_op = OP_SHR; cmd_mut = 1'b1; cmd_all = 1'b1; end
      CMD_DEC_ONE:     begin cmd_op = OP_DEC; cmd_mut = 1'b1; end
      CMD_DEC_ALL:     begin cmd_op = OP_DEC; cmd_mut = 1'b1; cmd_all = 1'b1; end
      CMD_SHL_ONE:     begin cmd_op = OP_SHL; cmd_mut = 1'b1; end
      CMD_SHL_ALL:     begin cmd_op = OP_SHL; cmd_mut = 1'b1; cmd_all = 1'b1; end
      CMD_INC_ONE:     begin cmd_op = OP_INC; cmd_mut = 1'b1; end
      CMD_INC_ALL:     begin cmd_op = OP_INC; cmd_mut = 1'b1; cmd_all = 1'b1; end
      default:         cmd_op = OP_HOLD;
    endcase
  end

  assign chan_ok = (cmd_chan_i < SELW'(NCH));

  // Arbitration: recall, then busy drop, then command, then direct write.
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      ch_op[i]    = OP_HOLD;
      ch_store[i] = 1'b0;
    end
    store_start   = 1'b0;
    restore_start = 1'b0;
    reject_d      = 1'b0;
    if (recall_i) begin
      for (int i = 0; i < NCH; i++) ch_op[i] = OP_RESTORE;
      restore_start = 1'b1;
      reject_d      = cmd_valid_i | wr_valid_i;
    end else if (busy_o) begin
      reject_d = cmd_valid_i | wr_valid_i;
    end else if (cmd_valid_i) begin
      reject_d = wr_valid_i;
      if (cmd_mut && wr_protect_i) begin
        reject_d = 1'b1;
      end else begin
        for (int i = 0; i < NCH; i++) begin
          if (cmd_all || (cmd_chan_i == SELW'(i))) begin
            ch_op[i]    = cmd_op;
            ch_store[i] = cmd_store;
          end
        end
        restore_start = (cmd_op == OP_RESTORE) && (cmd_all || chan_ok);
        store_start   = cmd_store && chan_ok;
      end
    end else if (wr_valid_i) begin
      if (wr_protect_i) begin
        reject_d = 1'b1;
      end else begin
        for (int i = 0; i < NCH; i++)
          if (wr_chan_i == SELW'(i)) ch_op[i] = OP_LOAD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reject_q <= 1'b0;
    else        reject_q <= reject_d;
  end

  assign reject_o = reject_q;

  wiper_busy_timer #(
    .STORE_CYC   (STORE_CYC),
    .RESTORE_CYC (RESTORE_CYC)
  ) timer_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .store_start_i   (store_start),
    .restore_start_i (restore_start),
    .busy_o          (busy_o)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int WG = (g < N_WIDE) ? W_WIDE : W_NARROW;
    wiper_channel #(.W(WG), .WMAX(WMAX)) chan_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_i    (ch_op[g]),
      .store_i (ch_store[g]),
      .data_i  (wr_data_i),
      .wiper_o (wiper_flat_o[g*WMAX +: WMAX])
    );
  end

endmodule

// File: rtl/wiper_cmd_engine_chk.sv
module wiper_cmd_engine_chk #(
  parameter  int N_WIDE      = 2,
  parameter  int N_NARROW    = 1,
  parameter  int W_WIDE      = 9,
  parameter  int W_NARROW    = 7,
  parameter  int STORE_CYC   = 40,
  parameter  int RESTORE_CYC = 6,
  localparam int NCH         = N_WIDE + N_NARROW,
  localparam int WMAX        = (W_WIDE > W_NARROW) ? W_WIDE : W_NARROW,
  localparam int SELW        = (NCH > 1) ? $clog2(NCH + 1) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                recall_i,
  input logic                wr_protect_i,
  input logic                cmd_valid_i,
  input logic [3:0]          cmd_code_i,
  input logic [SELW-1:0]     cmd_chan_i,
  input logic                wr_valid_i,
  input logic [SELW-1:0]     wr_chan_i,
  input logic [WMAX-1:0]     wr_data_i,
  input logic                busy_o,
  input logic                reject_o,
  input logic [NCH*WMAX-1:0] wiper_flat_o
);

  localparam logic [WMAX-1:0] FULL_W = WMAX'((1 << W_WIDE) - 1);
  localparam logic [WMAX-1:0] FULL_N = WMAX'((1 << W_NARROW) - 1);

  logic go;
  logic [WMAX-1:0] slot_first, slot_last;
  assign go = cmd_valid_i && !busy_o && !recall_i && !wr_protect_i;
  assign slot_first = wiper_flat_o[0 +: WMAX];
  assign slot_last  = wiper_flat_o[(NCH-1)*WMAX +: WMAX];

  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && (cmd_valid_i || wr_valid_i)) |=> reject_o) else $error("busy drop"); // R8

  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !recall_i) |=> $stable(wiper_flat_o)) else $error("busy frozen"); // R8

  AST_PROTECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_protect_i && !recall_i &&
     !(cmd_valid_i && (cmd_code_i == 4'h1 || cmd_code_i == 4'h7)))
    |=> $stable(wiper_flat_o)) else $error("protect"); // R9

  AST_RECALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    recall_i |=> busy_o) else $error("recall busy"); // R7

  AST_INC_SAT_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd_code_i == 4'hB && slot_first == FULL_W) |=> (slot_first == FULL_W))
    else $error("inc sat wide"); // R3

  AST_INC_SAT_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd_code_i == 4'hB && slot_last == FULL_N) |=> (slot_last == FULL_N))
    else $error("inc sat narrow"); // R11

  AST_SHL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd_code_i == 4'h9 && slot_first == '0) |=> (slot_first == WMAX'(1)))
    else $error("shl zero"); // R4

endmodule

bind wiper_cmd_engine wiper_cmd_engine_chk #(
  .N_WIDE      (N_WIDE),
  .N_NARROW    (N_NARROW),
  .W_WIDE      (W_WIDE),
  .W_NARROW    (W_NARROW),
  .STORE_CYC   (STORE_CYC),
  .RESTORE_CYC (RESTORE_CYC)
) chk_i (.*);

// File: tb/wiper_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module wiper_cmd_engine_tb_top;

  localparam int STORE_CYC   = 40;
  localparam int RESTORE_CYC = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        recall_i, wr_protect_i, cmd_valid_i, wr_valid_i;
  logic [3:0]  cmd_code_i;
  logic [1:0]  cmd_chan_i, wr_chan_i;
  logic [8:0]  wr_data_i;
  logic        busy_o, reject_o;
  logic [26:0] wiper_flat_o;

  int n_chk = 0;
  int n_bad = 0;
  int expv [3];
  bit finished = 0;

  always #2 clk = ~clk;

  wiper_cmd_engine #(.STORE_CYC(STORE_CYC), .RESTORE_CYC(RESTORE_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .recall_i(recall_i), .wr_protect_i(wr_protect_i),
    .cmd_valid_i(cmd_valid_i), .cmd_code_i(cmd_code_i), .cmd_chan_i(cmd_chan_i),
    .wr_valid_i(wr_valid_i), .wr_chan_i(wr_chan_i), .wr_data_i(wr_data_i),
    .busy_o(busy_o), .reject_o(reject_o), .wiper_flat_o(wiper_flat_o)
  );

  function automatic int fullv(int ch);
    return (ch < 2) ? 511 : 127;
  endfunction

  function automatic int slot(int ch);
    return int'(wiper_flat_o[ch*9 +: 9]);
  endfunction

  function automatic int model(int code, int v, int full);
    case (code)
      4'hA, 4'hB: return (v == full) ? full : v + 1;
      4'h5, 4'h6: return (v == 0) ? 0 : v - 1;
      4'h8, 4'h9: return (v == 0) ? 1 : ((v >= (full + 1) / 2) ? full : v * 2);
      4'h3, 4'h4: return v / 2;
      default:    return v;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic chk_all(string req);
    for (int i = 0; i < 3; i++) chk(req, slot(i), expv[i]);
  endtask

  task automatic send_cmd(int code, int ch);
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_code_i = 4'(code); cmd_chan_i = 2'(ch);
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic send_wr(int ch, int d);
    @(negedge clk);
    wr_valid_i = 1'b1; wr_chan_i = 2'(ch); wr_data_i = 9'(d);
    @(negedge clk);
    wr_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; recall_i = 0; wr_protect_i = 0; cmd_valid_i = 0; wr_valid_i = 0;
    cmd_code_i = 0; cmd_chan_i = 0; wr_chan_i = 0; wr_data_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expv[0] = 256; expv[1] = 256; expv[2] = 64;
    chk_all("R1 reset wiper");
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 reject", int'(reject_o), 0);

    // R1: shadows at midscale, seen through restore-all.
    send_wr(0, 9); send_wr(1, 400); send_wr(2, 3);
    send_cmd(4'h7, 0);
    chk_all("R1 shadow midscale");
    wait_idle();

    // Sweeps over every value of every channel: R2, R3, R4, R5.
    for (int ch = 0; ch < 3; ch++) begin
      for (int v = 0; v <= fullv(ch); v++) begin
        send_wr(ch, v); expv[ch] = v;
        chk("R2 write", slot(ch), v);
        chk("R2 no busy", int'(busy_o), 0);
        send_cmd(4'h8, ch); expv[ch] = model(4'h8, v, fullv(ch));
        chk("R4 shift left", slot(ch), expv[ch]);
        send_wr(ch, v);
        send_cmd(4'h3, ch); expv[ch] = model(4'h3, v, fullv(ch));
        chk("R5 shift right", slot(ch), expv[ch]);
        send_wr(ch, v);
        send_cmd(4'hA, ch); expv[ch] = model(4'hA, v, fullv(ch));
        chk("R3 inc", slot(ch), expv[ch]);
        send_wr(ch, v);
        send_cmd(4'h5, ch); expv[ch] = model(4'h5, v, fullv(ch));
        chk("R3 dec", slot(ch), expv[ch]);
      end
    end
    chk_all("R2 others untouched");

    // R2: truncation on the narrow channel.
    send_wr(2, 9'h1C5); expv[2] = 9'h1C5 & 9'h07F;
    chk_all("R2 truncate");

    // R11: all-channel commands with per-width clamps.
    send_wr(0, 300); send_wr(1, 0); send_wr(2, 100);
    send_cmd(4'h9, 0); expv[0] = 511; expv[1] = 1; expv[2] = 127;
    chk_all("R11 shl all");
    send_wr(1, 5);
    send_cmd(4'hB, 0); expv[0] = 511; expv[1] = 6; expv[2] = 127;
    chk_all("R11 inc all");
    send_wr(0, 0); send_wr(1, 1); send_wr(2, 64);
    send_cmd(4'h6, 0); expv[0] = 0; expv[1] = 0; expv[2] = 63;
    chk_all("R11 dec all");
    send_wr(0, 511); send_wr(1, 3); send_wr(2, 127);
    send_cmd(4'h4, 0); expv[0] = 255; expv[1] = 1; expv[2] = 63;
    chk_all("R11 shr all");

    // R6: store and busy window.
    send_wr(1, 77); expv[1] = 77;
    send_cmd(4'h2, 1);
    chk("R6 busy high", int'(busy_o), 1);
    busy_len(n);
    chk("R6 store busy cycles", n, STORE_CYC);
    // R7: single restore.
    send_wr(1, 5);
    send_cmd(4'h1, 1); expv[1] = 77;
    chk_all("R7 restore one");
    busy_len(n);
    chk("R7 restore busy cycles", n, RESTORE_CYC);

    // R8: requests during busy dropped.
    send_cmd(4'h2, 0);
    send_wr(0, 3);
    chk("R8 write reject", int'(reject_o), 1);
    chk_all("R8 write ignored");
    send_cmd(4'hA, 0);
    chk("R8 cmd reject", int'(reject_o), 1);
    chk_all("R8 cmd ignored");
    wait_idle();
    @(negedge clk);
    chk("R8 reject clears", int'(reject_o), 0);

    // R8: write and command together; command wins.
    @(negedge clk);
    cmd_valid_i = 1; cmd_code_i = 4'hA; cmd_chan_i = 2;
    wr_valid_i = 1; wr_chan_i = 0; wr_data_i = 9'd1;
    @(negedge clk);
    cmd_valid_i = 0; wr_valid_i = 0;
    expv[2] = expv[2] + 1;
    chk_all("R8 cmd over write");
    chk("R8 write flagged", int'(reject_o), 1);

    // R7/R8: recall with simultaneous write.
    @(negedge clk);
    recall_i = 1; wr_valid_i = 1; wr_chan_i = 2; wr_data_i = 9'd9;
    @(negedge clk);
    recall_i = 0; wr_valid_i = 0;
    expv[0] = 255; expv[1] = 77; expv[2] = 64;
    chk_all("R7 recall");
    chk("R8 recall drops write", int'(reject_o), 1);
    chk("R7 recall busy", int'(busy_o), 1);
    wait_idle();

    // R9: write protect.
    send_wr(0, 10); expv[0] = 10;
    wr_protect_i = 1;
    send_wr(0, 1);
    chk("R9 write flagged", int'(reject_o), 1);
    chk_all("R9 write blocked");
    send_cmd(4'hB, 0);
    chk("R9 inc flagged", int'(reject_o), 1);
    chk_all("R9 inc blocked");
    send_cmd(4'h2, 0);
    chk("R9 store blocked busy", int'(busy_o), 0);
    chk("R9 store flagged", int'(reject_o), 1);
    send_cmd(4'h1, 0); expv[0] = 255;
    chk_all("R9 restore allowed");
    wait_idle();
    send_cmd(4'h0, 0);
    chk("R9 nop not flagged", int'(reject_o), 0);
    wr_protect_i = 0;
    send_wr(0, 10); expv[0] = 10;
    wr_protect_i = 1;
    @(negedge clk); recall_i = 1;
    @(negedge clk); recall_i = 0; expv[0] = 255;
    chk_all("R9 recall allowed");
    wait_idle();
    wr_protect_i = 0;

    // R10: no-op, reserved codes and channel 3.
    for (int c = 12; c < 16; c++) begin
      send_cmd(c, 0);
      chk_all("R10 reserved");
      chk("R10 reserved no flag", int'(reject_o), 0);
      chk("R10 reserved no busy", int'(busy_o), 0);
    end
    send_cmd(4'hA, 3);
    chk_all("R10 channel 3");
    chk("R10 channel 3 no flag", int'(reject_o), 0);
    send_cmd(4'h1, 3);
    chk("R10 restore ch3 no busy", int'(busy_o), 0);
    send_cmd(4'h0, 1);
    chk_all("R10 nop");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule